// File: doc/BRIEF.md
# Linear Soft Mute Ramp Controller

This block fades an audio stream in and out without clicks. A gain counter moves one step for each input frame strobe. It steps toward zero while the mute request is high and toward unity while the request is low. Every incoming signed sample is multiplied by the current gain over 4096, truncated back to the sample width and registered. The full fade in either direction takes 4096 frames. After reset the block starts fully muted, so the stream fades in once the mute request is released.

A separate mute-status flag is raised by reset or by a rate-change pulse. It stays high until a settling-done pulse arrives from the rate-tracking loop. That loop lives outside this block, so both events arrive on input pins. The ramp is purely linear in amplitude, with no logarithmic shaping.

Top module: `smr_soft_mute`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `gain_lvl` is 0, `mute_stat` is 1 and `out_vld` is 0.
- R2: On a cycle with `frame_stb` high, `gain_lvl` drops by one if `mute_req` is 1 and rises by one if `mute_req` is 0. Without `frame_stb`, `gain_lvl` is unchanged whatever `mute_req` does.
- R3: `gain_lvl` saturates: it stays at 0 on a down step and at 4096 (unity) on an up step, never wrapping.
- R4: A full transition takes exactly 4096 frames: from 0, 4095 up-frames give 4095 and the 4096th gives 4096. The same count applies downward from 4096.
- R5: When `mute_req` changes mid-ramp, the next frame moves `gain_lvl` by exactly one from its present value in the new direction, with no jump.
- R6: The scaled sample is floor(x*g/4096) in two's complement, where x is the signed `in_dat` and g is `gain_lvl`. With g = 4096 the output equals the input exactly, including the most negative value. With g = 0 the output is 0.
- R7: `out_vld` is high exactly in the cycle after `in_vld` is high, and `out_dat` changes only then. A sample that arrives together with a frame strobe is scaled by the gain before that strobe's step.
- R8: `mute_stat` goes high the cycle after a `rate_chg` pulse and goes low the cycle after a `settle_done` pulse. When both pulse in the same cycle, `rate_chg` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per input audio frame; steps the ramp |
| mute_req | input | 1 | 1 ramps toward silence, 0 ramps toward unity |
| in_vld | input | 1 | Input sample valid |
| in_dat | input | 24 | Signed input sample |
| rate_chg | input | 1 | Pulse: sample-rate change detected |
| settle_done | input | 1 | Pulse: rate-tracking loop has finished fast settling |
| out_vld | output | 1 | Scaled sample valid, one cycle after in_vld |
| out_dat | output | 24 | Signed scaled sample |
| gain_lvl | output | 13 | Current gain count, 0 (silent) to 4096 (unity) |
| mute_stat | output | 1 | High from reset or rate change until settling done |

## Verification
The bench walks the ramp across both end points. It counts frames to show that unity and silence are each reached on exactly the 4096th step. A wrapping counter would instead jump to the far end, and an off-by-one limit would stop at 4095 or overshoot. Negative samples at fractional gains check that truncation rounds toward minus infinity and not toward zero. The most negative sample at unity would expose a product that drops the gain's top bit. Mid-ramp reversals, and frames that coincide with samples, would catch a design that restarts the ramp or scales with the already-stepped gain. Rate-change and settling pulses arriving together check the status priority.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/smr_ramp_ctr.sv
module smr_ramp_ctr
  import smr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic             mute_req,
  output logic [CNT_W:0]   gain_q
);
  localparam logic [CNT_W:0] G_MAX = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] G_ONE = {{CNT_W{1'b0}}, 1'b1};

  ramp_dir_e      dir;
  logic [CNT_W:0] gain_d;

  always_comb dir = mute_req ? DIR_DOWN : DIR_UP;

  always_comb begin
    gain_d = gain_q;
    if (frame_stb) begin
      if (dir == DIR_DOWN) begin
        if (gain_q != '0) gain_d = gain_q - G_ONE;
      end else begin
        if (gain_q != G_MAX) gain_d = gain_q + G_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gain_q <= '0;
    else     gain_q <= gain_d;
  end

  AST_STEP_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_stb) |-> $stable(gain_q)); // R2
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !mute_req && gain_q == G_MAX) |=> gain_q == G_MAX); // R3
  AST_SAT_BOT: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && mute_req && gain_q == '0) |=> gain_q == '0); // R3
  AST_NO_JUMP: assert property (@(posedge clk) disable iff (rst)
    (gain_q == $past(gain_q) + G_ONE) || (gain_q == $past(gain_q) - G_ONE)
    || (gain_q == $past(gain_q))); // R5
  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    gain_q <= G_MAX); // R3
endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_vld,
  input  logic signed [DATA_W-1:0] in_dat,
  input  logic        [CNT_W:0]    gain,
  output logic                     out_vld,
  output logic signed [DATA_W-1:0] out_dat
);
  localparam int PROD_W = DATA_W + CNT_W + 2;
  localparam logic [CNT_W:0] G_MAX = {1'b1, {CNT_W{1'b0}}};

  logic signed [CNT_W+1:0]   gain_s;
  logic signed [PROD_W-1:0]  prod;
  logic signed [DATA_W-1:0]  scaled;

  always_comb begin
    gain_s = $signed({1'b0, gain});
    prod   = in_dat * gain_s;
    scaled = DATA_W'(prod >>> CNT_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_dat <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_dat <= scaled;
    end
  end

  AST_VLD_LAT: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld); // R7
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!out_vld && $stable(out_dat))); // R7
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_vld && gain == G_MAX) |=> out_dat == $past(in_dat)); // R6
  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (rst)
    (in_vld && gain == '0) |=> out_dat == '0); // R6
endmodule

// File: rtl/smr_mute_status.sv
module smr_mute_status (
  input  logic clk,
  input  logic rst,
  input  logic rate_chg,
  input  logic settle_done,
  output logic mute_stat
);
  always_ff @(posedge clk) begin
    if (rst)              mute_stat <= 1'b1;
    else if (rate_chg)    mute_stat <= 1'b1;
    else if (settle_done) mute_stat <= 1'b0;
  end

  AST_STAT_SET: assert property (@(posedge clk) disable iff (rst)
    rate_chg |=> mute_stat); // R8
  AST_STAT_CLR: assert property (@(posedge clk) disable iff (rst)
    (settle_done && !rate_chg) |=> !mute_stat); // R8
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!settle_done && !rate_chg) |=> $stable(mute_stat)); // R8
endmodule

// File: rtl/smr_soft_mute.sv
module smr_soft_mute #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_stb,
  input  logic                     mute_req,
  input  logic                     in_vld,
  input  logic signed [DATA_W-1:0] in_dat,
  input  logic                     rate_chg,
  input  logic                     settle_done,
  output logic                     out_vld,
  output logic signed [DATA_W-1:0] out_dat,
  output logic        [CNT_W:0]    gain_lvl,
  output logic                     mute_stat
);
  logic [CNT_W:0] gain_w;

  smr_ramp_ctr #(.CNT_W(CNT_W)) u_ramp (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .mute_req  (mute_req),
    .gain_q    (gain_w)
  );

  smr_scaler #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_scale (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_dat  (in_dat),
    .gain    (gain_w),
    .out_vld (out_vld),
    .out_dat (out_dat)
  );

  smr_mute_status u_stat (
    .clk         (clk),
    .rst         (rst),
    .rate_chg    (rate_chg),
    .settle_done (settle_done),
    .mute_stat   (mute_stat)
  );

  always_comb gain_lvl = gain_w;

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (gain_lvl == '0 && mute_stat && !out_vld)); // R1
endmodule

// File: tb/tb_smr_soft_mute.sv
`timescale 1ns/1ps
module tb_smr_soft_mute;
  localparam int DW = 24;
  localparam int CW = 12;
  localparam longint GMAX = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0, mute_req = 1'b1, in_vld = 1'b0;
  logic signed [DW-1:0] in_dat = '0;
  logic rate_chg = 1'b0, settle_done = 1'b0;
  logic out_vld, mute_stat;
  logic signed [DW-1:0] out_dat;
  logic [CW:0] gain_lvl;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  smr_soft_mute #(.DATA_W(DW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .mute_req(mute_req),
    .in_vld(in_vld), .in_dat(in_dat), .rate_chg(rate_chg),
    .settle_done(settle_done), .out_vld(out_vld), .out_dat(out_dat),
    .gain_lvl(gain_lvl), .mute_stat(mute_stat)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint scale_ref(longint x, longint g);
    longint p;
    p = x * g;
    return p >>> 12;
  endfunction

  task automatic frames(int n, bit dn);
    mute_req = dn;
    frame_stb = 1'b1;
    repeat (n) tick();
    frame_stb = 1'b0;
  endtask

  task automatic send(longint x);
    longint g;
    g = longint'(gain_lvl);
    in_dat = DW'(x);
    in_vld = 1'b1;
    tick();
    in_vld = 1'b0;
    chk("R7 valid", longint'(out_vld), 1);
    chk("R6 scaled", longint'(out_dat), scale_ref(x, g));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    chk("R1 gain in reset", longint'(gain_lvl), 0);
    chk("R1 stat in reset", longint'(mute_stat), 1);
    chk("R1 vld in reset", longint'(out_vld), 0);
    rst = 1'b0;
    tick();
    chk("R1 gain after", longint'(gain_lvl), 0);
    chk("R1 stat after", longint'(mute_stat), 1);
    send(1000);
    chk("R6 zero gain", longint'(out_dat), 0);
  endtask

  task automatic t_ramp_up();
    frames(4095, 1'b0);
    chk("R4 up 4095", longint'(gain_lvl), 4095);
    frames(1, 1'b0);
    chk("R4 up 4096", longint'(gain_lvl), GMAX);
    frames(3, 1'b0);
    chk("R3 top sat", longint'(gain_lvl), GMAX);
  endtask

  task automatic t_scale();
    send(-8388608);
    chk("R6 unity min", longint'(out_dat), -8388608);
    send(8388607);
    send(12345);
    frames(1000, 1'b1);
    chk("R2 down 1000", longint'(gain_lvl), 3096);
    send(-1);
    send(5);
    send(-5);
    chk("R6 floor neg", longint'(out_dat), -4);
    send(-8388608);
    send(7777777);
  endtask

  task automatic t_hold();
    longint g0, d0;
    g0 = longint'(gain_lvl);
    d0 = longint'(out_dat);
    mute_req = 1'b0; tick();
    mute_req = 1'b1; tick();
    mute_req = 1'b0; tick();
    chk("R2 no strobe", longint'(gain_lvl), g0);
    chk("R7 idle vld", longint'(out_vld), 0);
    chk("R7 idle hold", longint'(out_dat), d0);
  endtask

  task automatic t_reverse();
    longint g;
    frames(50, 1'b1);
    chk("R2 down 50", longint'(gain_lvl), 3046);
    for (int i = 0; i < 20; i++) begin
      g = longint'(gain_lvl);
      frames(1, 1'b0);
      chk("R5 reverse up", longint'(gain_lvl), g + 1);
    end
    g = longint'(gain_lvl);
    frames(1, 1'b1);
    chk("R5 reverse down", longint'(gain_lvl), g - 1);
  endtask

  task automatic t_same_cycle();
    longint g;
    g = longint'(gain_lvl);
    mute_req = 1'b1;
    frame_stb = 1'b1;
    in_dat = DW'(-300001);
    in_vld = 1'b1;
    tick();
    frame_stb = 1'b0;
    in_vld = 1'b0;
    chk("R7 pre-step gain", longint'(out_dat), scale_ref(-300001, g));
    chk("R2 stepped", longint'(gain_lvl), g - 1);
  endtask

  task automatic t_ramp_down();
    frames(2000, 1'b0);
    chk("R3 top again", longint'(gain_lvl), GMAX);
    frames(4095, 1'b1);
    chk("R4 down 4095", longint'(gain_lvl), 1);
    send(-8388608);
    chk("R6 min at g1", longint'(out_dat), -2048);
    frames(1, 1'b1);
    chk("R4 down 4096", longint'(gain_lvl), 0);
    frames(5, 1'b1);
    chk("R3 bottom sat", longint'(gain_lvl), 0);
    send(-8388608);
  endtask

  task automatic t_status();
    settle_done = 1'b1; tick(); settle_done = 1'b0;
    chk("R8 clear", longint'(mute_stat), 0);
    tick();
    chk("R8 hold low", longint'(mute_stat), 0);
    rate_chg = 1'b1; tick(); rate_chg = 1'b0;
    chk("R8 set", longint'(mute_stat), 1);
    settle_done = 1'b1; tick(); settle_done = 1'b0;
    chk("R8 clear 2", longint'(mute_stat), 0);
    rate_chg = 1'b1; settle_done = 1'b1; tick();
    rate_chg = 1'b0; settle_done = 1'b0;
    chk("R8 priority", longint'(mute_stat), 1);
  endtask

  initial begin
    #(200000 * 8);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_ramp_up();
    t_scale();
    t_hold();
    t_reverse();
    t_same_cycle();
    t_ramp_down();
    t_status();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule